// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic store-class operation at a time against a simple single-port memory. A caller presents an operation code, an access size, a base value, a signed 16-bit displacement, a source value and the accumulator value (R0), then pulses `start`. The unit forms the target address, reads the old memory value, computes the new value, writes it back (the write is skipped only when a compare-and-exchange finds a mismatch), and finally reports the register values to be written back into the source register or into R0.

The unit is the only memory master while `busy` is high, so the read and the write form one locked transaction. The memory side is a 64-bit data bus with byte enables and a request/acknowledge handshake that may stretch for any number of wait cycles. A 32-bit operation uses the lower or upper half of the 64-bit bus as chosen by address bit 2. Unsupported sizes and unknown operation codes are flagged and cause no memory traffic.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The memory address is `dst_val + sign_extend(off_val)`. A doubleword access drives `mem_be = 8'hFF`; a word access drives `mem_be = 8'h0F` with data in bits 31:0 when address bit 2 is 0, and `mem_be = 8'hF0` with data in bits 63:32 when address bit 2 is 1.
- R2: The operation is selected by `op_imm[7:4]`: 0x0 add, 0x4 or, 0x5 and, 0xA xor; the new memory value is the old value combined with `src_val`, and with `op_imm[0]` (fetch bit) clear no register writeback is reported.
- R3: With `op_size = 2'b10` (word) the operation uses 32-bit operands, wraps at 32 bits, and leaves the other half of the 64-bit memory word untouched; `op_size = 2'b11` selects doubleword (64-bit).
- R4: For add/or/and/xor with the fetch bit set, `src_wb_en` pulses with `done` and `src_wb_data` holds the memory value from before the update, zero-extended for word size.
- R5: Exchange (`op_imm = 0xE1`) writes `src_val` to memory and returns the old memory value through `src_wb_data` with `src_wb_en`.
- R6: Compare-and-exchange (`op_imm = 0xF1`) compares the old memory value with `r0_val` (low 32 bits only for word size); on a match it writes `src_val` to memory.
- R7: Compare-and-exchange always reports the old memory value, zero-extended, through `r0_wb_data` with `r0_wb_en`, and performs no memory write when the values differ; it never asserts `src_wb_en`.
- R8: Size codes `2'b00`/`2'b01`, a nonzero `op_imm[31:8]` or `op_imm[3:1]`, an unknown `op_imm[7:4]`, or exchange/compare-and-exchange without the fetch bit raise `illegal` together with `done`, with no memory request and no register writeback.
- R9: `busy` is high from the cycle after `start` is accepted until the cycle of the one-cycle `done` pulse; `start` while busy is ignored.
- R10: After reset `busy`, `done`, `mem_req` and both writeback enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_imm | input | 32 | Operation code |
| op_size | input | 2 | Access size code |
| dst_val | input | 64 | Base address value |
| off_val | input | 16 | Signed displacement |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Accumulator (R0) value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion was an illegal operation |
| src_wb_en | output | 1 | Write `src_wb_data` into the source register |
| src_wb_data | output | 64 | Source register writeback value |
| r0_wb_en | output | 1 | Write `r0_wb_data` into R0 |
| r0_wb_data | output | 64 | R0 writeback value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Request completes this cycle |

## Verification
The embedded assertions watch, on every cycle, that an illegal operation never reaches the memory bus, that a mismatching compare-and-exchange never proceeds to a write, that word accesses enable exactly four byte lanes, that the captured old value of a word operation is zero-extended, that `done` lasts one cycle and that the two writeback enables never coincide. Only the bench's scenarios can show the arithmetic results, the lane merge in memory, the exact writeback values, behaviour under wait states, a negative displacement, and that a `start` pulse during a busy operation starts nothing.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int XLEN     = 64;
    localparam int HALF     = XLEN / 2;
    localparam int BE_W     = XLEN / 8;
    localparam int LANE_BIT = $clog2(HALF / 8);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } amo_size_e;

    typedef enum logic [2:0] {
        K_ADD,
        K_OR,
        K_AND,
        K_XOR,
        K_XCHG,
        K_CMPX
    } amo_kind_e;

    localparam logic [3:0] CODE_ADD  = 4'h0;
    localparam logic [3:0] CODE_OR   = 4'h4;
    localparam logic [3:0] CODE_AND  = 4'h5;
    localparam logic [3:0] CODE_XOR  = 4'hA;
    localparam logic [3:0] CODE_XCHG = 4'hE;
    localparam logic [3:0] CODE_CMPX = 4'hF;

    typedef struct packed {
        amo_kind_e kind;
        logic      fetch;
        logic      dw;
        logic      illegal;
    } amo_op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_CALC,
        S_WRITE,
        S_DONE
    } amo_state_e;

    function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] v, input logic dw);
        return dw ? v : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    function automatic logic [XLEN-1:0] apply_op(input amo_kind_e k,
                                                 input logic [XLEN-1:0] mem_old,
                                                 input logic [XLEN-1:0] operand,
                                                 input logic dw);
        logic [XLEN-1:0] r;
        case (k)
            K_ADD:   r = mem_old + operand;
            K_OR:    r = mem_old | operand;
            K_AND:   r = mem_old & operand;
            K_XOR:   r = mem_old ^ operand;
            default: r = operand;
        endcase
        return narrow(r, dw);
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [1:0]       size,
    output amo_op_t          op
);
    logic size_ok;
    logic code_ok;
    logic pad_ok;

    always_comb begin
        op       = '0;
        op.kind  = K_ADD;
        op.fetch = imm[0];
        op.dw    = (size == SZ_DWORD);
        size_ok  = (size == SZ_WORD) || (size == SZ_DWORD);
        pad_ok   = (imm[IMM_W-1:8] == '0) && (imm[3:1] == 3'b000);
        code_ok  = 1'b1;
        case (imm[7:4])
            CODE_ADD:  op.kind = K_ADD;
            CODE_OR:   op.kind = K_OR;
            CODE_AND:  op.kind = K_AND;
            CODE_XOR:  op.kind = K_XOR;
            CODE_XCHG: begin
                op.kind = K_XCHG;
                code_ok = imm[0];
            end
            CODE_CMPX: begin
                op.kind = K_CMPX;
                code_ok = imm[0];
            end
            default:   code_ok = 1'b0;
        endcase
        op.illegal = !(size_ok && pad_ok && code_ok);
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
(
    input  amo_op_t         op,
    input  logic [XLEN-1:0] mem_old,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] r0,
    output logic [XLEN-1:0] new_val,
    output logic            match
);
    always_comb begin
        new_val = apply_op(op.kind, mem_old, src, op.dw);
        match   = (narrow(mem_old, op.dw) == narrow(r0, op.dw));
    end

endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  amo_op_t           op_in,
    input  logic [XLEN-1:0]   dst,
    input  logic [OFF_W-1:0]  offset,
    input  logic [XLEN-1:0]   src,
    input  logic [XLEN-1:0]   r0,
    input  logic [XLEN-1:0]   new_val,
    input  logic              match,
    output amo_op_t           cur_op,
    output logic [XLEN-1:0]   cur_old,
    output logic [XLEN-1:0]   cur_src,
    output logic [XLEN-1:0]   cur_r0,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              src_wb_en,
    output logic [XLEN-1:0]   src_wb_data,
    output logic              r0_wb_en,
    output logic [XLEN-1:0]   r0_wb_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ack
);
    localparam int EXT_W = ADDR_W - OFF_W;

    amo_state_e        state;
    amo_op_t           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [XLEN-1:0]   src_q;
    logic [XLEN-1:0]   r0_q;
    logic [XLEN-1:0]   old_q;
    logic [XLEN-1:0]   new_q;
    logic              upper;

    assign upper = addr_q[LANE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            op_q   <= '0;
            addr_q <= '0;
            src_q  <= '0;
            r0_q   <= '0;
            old_q  <= '0;
            new_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    op_q   <= op_in;
                    addr_q <= dst[ADDR_W-1:0] + {{EXT_W{offset[OFF_W-1]}}, offset};
                    src_q  <= src;
                    r0_q   <= r0;
                    state  <= op_in.illegal ? S_DONE : S_READ;
                end
                S_READ: if (mem_ack) begin
                    if (op_q.dw)
                        old_q <= mem_rdata;
                    else if (upper)
                        old_q <= {{HALF{1'b0}}, mem_rdata[XLEN-1:HALF]};
                    else
                        old_q <= {{HALF{1'b0}}, mem_rdata[HALF-1:0]};
                    state <= S_CALC;
                end
                S_CALC: begin
                    new_q <= new_val;
                    state <= (op_q.kind != K_CMPX || match) ? S_WRITE : S_DONE;
                end
                S_WRITE: if (mem_ack) state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cur_op   = op_q;
        cur_old  = old_q;
        cur_src  = src_q;
        cur_r0   = r0_q;
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        illegal  = done && op_q.illegal;
        mem_req  = (state == S_READ) || (state == S_WRITE);
        mem_we   = (state == S_WRITE);
        mem_addr = addr_q;
        if (op_q.dw) begin
            mem_be    = '1;
            mem_wdata = new_q;
        end else if (upper) begin
            mem_be    = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};
            mem_wdata = {new_q[HALF-1:0], {HALF{1'b0}}};
        end else begin
            mem_be    = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
            mem_wdata = {{HALF{1'b0}}, new_q[HALF-1:0]};
        end
        src_wb_en   = done && !op_q.illegal && op_q.fetch && (op_q.kind != K_CMPX);
        r0_wb_en    = done && !op_q.illegal && (op_q.kind == K_CMPX);
        src_wb_data = old_q;
        r0_wb_data  = old_q;
    end

    // R8: an illegal operation never issues a memory request
    a_r8_no_access_when_illegal: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !op_q.illegal);

    // R7: a mismatching compare-and-exchange goes straight to completion
    a_r7_no_write_on_mismatch: assert property (@(posedge clk) disable iff (rst)
        (state == S_CALC && op_q.kind == K_CMPX && !match) |=> (!mem_req && done));

    // R1: word accesses enable exactly one 32-bit lane
    a_r1_word_lane: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !op_q.dw) |-> ($countones(mem_be) == BE_W/2));

    // R3: a captured word value is zero-extended
    a_r3_old_narrow: assert property (@(posedge clk) disable iff (rst)
        (state == S_CALC && !op_q.dw) |-> (old_q[XLEN-1:HALF] == '0));

    // R9: completion is a single-cycle pulse and an accepted start raises busy
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R7: source and R0 writebacks never coincide
    a_r7_wb_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(src_wb_en && r0_wb_en));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IMM_W-1:0]  op_imm,
    input  logic [1:0]        op_size,
    input  logic [XLEN-1:0]   dst_val,
    input  logic [OFF_W-1:0]  off_val,
    input  logic [XLEN-1:0]   src_val,
    input  logic [XLEN-1:0]   r0_val,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              src_wb_en,
    output logic [XLEN-1:0]   src_wb_data,
    output logic              r0_wb_en,
    output logic [XLEN-1:0]   r0_wb_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ack
);
    amo_op_t         dec_op;
    amo_op_t         cur_op;
    logic [XLEN-1:0] cur_old;
    logic [XLEN-1:0] cur_src;
    logic [XLEN-1:0] cur_r0;
    logic [XLEN-1:0] new_val;
    logic            match;

    amo_decode #(.IMM_W(IMM_W)) u_decode (
        .imm  (op_imm),
        .size (op_size),
        .op   (dec_op)
    );

    amo_alu u_alu (
        .op      (cur_op),
        .mem_old (cur_old),
        .src     (cur_src),
        .r0      (cur_r0),
        .new_val (new_val),
        .match   (match)
    );

    amo_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .op_in       (dec_op),
        .dst         (dst_val),
        .offset      (off_val),
        .src         (src_val),
        .r0          (r0_val),
        .new_val     (new_val),
        .match       (match),
        .cur_op      (cur_op),
        .cur_old     (cur_old),
        .cur_src     (cur_src),
        .cur_r0      (cur_r0),
        .busy        (busy),
        .done        (done),
        .illegal     (illegal),
        .src_wb_en   (src_wb_en),
        .src_wb_data (src_wb_data),
        .r0_wb_en    (r0_wb_en),
        .r0_wb_data  (r0_wb_data),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_be      (mem_be),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack)
    );

endmodule

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] op_imm = '0;
    logic [1:0]  op_size = 2'b11;
    logic [63:0] dst_val = '0;
    logic [15:0] off_val = '0;
    logic [63:0] src_val = '0;
    logic [63:0] r0_val = '0;
    logic        busy, done, illegal, src_wb_en, r0_wb_en;
    logic [63:0] src_wb_data, r0_wb_data;
    logic        mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  mem_be;

    logic [63:0] mem [0:15];
    int lat = 0;
    int lat_cnt = 0;
    int acc_cnt = 0;
    int wr_cnt = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    atomic_rmw_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .op_imm(op_imm), .op_size(op_size),
        .dst_val(dst_val), .off_val(off_val), .src_val(src_val), .r0_val(r0_val),
        .busy(busy), .done(done), .illegal(illegal),
        .src_wb_en(src_wb_en), .src_wb_data(src_wb_data),
        .r0_wb_en(r0_wb_en), .r0_wb_data(r0_wb_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign mem_ack   = mem_req && (lat_cnt == lat);
    assign mem_rdata = mem[mem_addr[6:3]];

    always @(posedge clk) begin
        if (mem_req && !mem_ack) lat_cnt <= lat_cnt + 1;
        else                     lat_cnt <= 0;
        if (mem_req && mem_ack) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) mem[mem_addr[6:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_new(input logic [3:0] code, input logic dw,
                                            input logic [63:0] m, input logic [63:0] s);
        logic [63:0] r;
        case (code)
            4'h0:    r = m + s;
            4'h4:    r = m | s;
            4'h5:    r = m & s;
            4'hA:    r = m ^ s;
            default: r = s;
        endcase
        return dw ? r : {32'h0, r[31:0]};
    endfunction

    task automatic run_op(input string req, input logic [31:0] imm, input logic [1:0] sz,
                          input logic [63:0] dst, input logic [15:0] off,
                          input logic [63:0] src, input logic [63:0] r0, input bit poke);
        logic [63:0] addr, full, old, nv, exp_mem;
        logic dw, hi, legal, cmpx, match, writes;
        int wr0, acc0, n;
        addr  = dst + {{48{off[15]}}, off};
        dw    = (sz == 2'b11);
        hi    = addr[2];
        full  = mem[addr[6:3]];
        old   = dw ? full : (hi ? {32'h0, full[63:32]} : {32'h0, full[31:0]});
        legal = (sz[1] == 1'b1) && (imm[31:8] == 0) && (imm[3:1] == 0) &&
                ((imm[7:4] inside {4'h0, 4'h4, 4'h5, 4'hA}) ||
                 ((imm[7:4] inside {4'hE, 4'hF}) && imm[0]));
        cmpx  = (imm[7:4] == 4'hF);
        match = dw ? (old == r0) : (old[31:0] == r0[31:0]);
        writes = legal && (!cmpx || match);
        nv    = ref_new(imm[7:4], dw, old, src);
        exp_mem = full;
        if (writes) exp_mem = dw ? nv : (hi ? {nv[31:0], full[31:0]} : {full[63:32], nv[31:0]});
        wr0  = wr_cnt;
        acc0 = acc_cnt;

        @(negedge clk);
        start = 1'b1; op_imm = imm; op_size = sz; dst_val = dst; off_val = off;
        src_val = src; r0_val = r0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
        if (poke) begin
            start = 1'b1; op_imm = 32'h41; src_val = 64'hDEAD;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 100) begin @(negedge clk); n++; end
        chk(done == 1'b1, req, "done seen", 64'(done), 64'd1);
        chk(illegal == !legal, legal ? req : "R8", "illegal flag", 64'(illegal), 64'(!legal));
        chk(src_wb_en == (legal && imm[0] && !cmpx), legal ? req : "R8", "src_wb_en",
            64'(src_wb_en), 64'(legal && imm[0] && !cmpx));
        if (legal && imm[0] && !cmpx)
            chk(src_wb_data == old, req, "src_wb_data", src_wb_data, old);
        chk(r0_wb_en == (legal && cmpx), legal ? req : "R8", "r0_wb_en",
            64'(r0_wb_en), 64'(legal && cmpx));
        if (legal && cmpx)
            chk(r0_wb_data == old, "R7", "r0_wb_data", r0_wb_data, old);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9", "idle after done", 64'({busy, done}), 64'd0);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R9", "no extra start", 64'(busy), 64'd0);
        chk(mem[addr[6:3]] == exp_mem, req, "memory word", mem[addr[6:3]], exp_mem);
        chk(wr_cnt - wr0 == int'(writes), req, "write count", 64'(wr_cnt - wr0), 64'(writes));
        if (!legal) chk(acc_cnt == acc0, "R8", "no access", 64'(acc_cnt - acc0), 64'd0);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !mem_req && !src_wb_en && !r0_wb_en, "R10", "reset outputs",
            64'({busy, done, mem_req, src_wb_en, r0_wb_en}), 64'd0);
    endtask

    task automatic t_simple_ops;
        lat = 0;
        mem[1] = 64'h0000_0001_FFFF_FFFF;
        run_op("R2", 32'h00, 2'b11, 64'h8, 16'h0, 64'h1, 0, 0);       // dword add carries into bit 32
        mem[2] = 64'h1111_2222_3333_4444;
        run_op("R2", 32'h40, 2'b10, 64'h10, 16'h0, 64'h0F0F, 0, 0);   // word or, low lane
        run_op("R1", 32'h50, 2'b10, 64'h10, 16'h4, 64'hFFFF_0000, 0, 0); // word and, high lane
        mem[3] = 64'hAAAA_5555_AAAA_5555;
        run_op("R2", 32'hA0, 2'b11, 64'h18, 16'h0, 64'hFFFF_FFFF_0000_0000, 0, 0);
    endtask

    task automatic t_word_wrap;
        lat = 1;
        mem[4] = 64'hCAFE_BABE_FFFF_FFFF;
        run_op("R3", 32'h00, 2'b10, 64'h20, 16'h0, 64'h9999_0000_0000_0002, 0, 0);
        chk(mem[4] == 64'hCAFE_BABE_0000_0001, "R3", "wrap and upper lane kept",
            mem[4], 64'hCAFE_BABE_0000_0001);
    endtask

    task automatic t_fetch;
        lat = 2;
        mem[5] = 64'h8000_0000_7FFF_FFFF;
        run_op("R4", 32'h01, 2'b10, 64'h28, 16'h4, 64'h5, 0, 0);
        run_op("R4", 32'hA1, 2'b11, 64'h28, 16'h0, 64'h0123_4567_89AB_CDEF, 0, 0);
    endtask

    task automatic t_xchg;
        lat = 0;
        mem[6] = 64'h1234_5678_9ABC_DEF0;
        run_op("R5", 32'hE1, 2'b11, 64'h30, 16'h0, 64'h0BAD_F00D_0BAD_F00D, 0, 0);
        chk(mem[6] == 64'h0BAD_F00D_0BAD_F00D, "R5", "exchanged value", mem[6], 64'h0BAD_F00D_0BAD_F00D);
    endtask

    task automatic t_cmpx;
        lat = 1;
        mem[7] = 64'h0000_0042_0000_0017;
        run_op("R6", 32'hF1, 2'b11, 64'h38, 16'h0, 64'h77, 64'h0000_0042_0000_0017, 0);
        mem[8] = 64'h5555_6666_7777_8888;
        run_op("R6", 32'hF1, 2'b10, 64'h40, 16'h4, 64'hABCD, 64'hFFFF_FFFF_5555_6666, 0);
        run_op("R7", 32'hF1, 2'b10, 64'h40, 16'h0, 64'h1, 64'h0000_0000_7777_8889, 0);
        run_op("R7", 32'hF1, 2'b11, 64'h38, 16'h0, 64'h2, 64'h0, 0);
    endtask

    task automatic t_illegal;
        lat = 0;
        mem[9] = 64'h0F0F_0F0F_0F0F_0F0F;
        run_op("R8", 32'h00, 2'b00, 64'h48, 16'h0, 64'h1, 0, 0);
        run_op("R8", 32'h01, 2'b01, 64'h48, 16'h0, 64'h1, 0, 0);
        run_op("R8", 32'h30, 2'b11, 64'h48, 16'h0, 64'h1, 0, 0);
        run_op("R8", 32'hE0, 2'b11, 64'h48, 16'h0, 64'h1, 0, 0);
        run_op("R8", 32'h100, 2'b11, 64'h48, 16'h0, 64'h1, 0, 0);
        run_op("R8", 32'h02, 2'b10, 64'h48, 16'h0, 64'h1, 0, 0);
    endtask

    task automatic t_busy_ignore;
        lat = 3;
        mem[10] = 64'h0000_0000_0000_0010;
        run_op("R9", 32'h00, 2'b11, 64'h50, 16'h0, 64'h5, 0, 1);
        chk(mem[10] == 64'h15, "R9", "only first op applied", mem[10], 64'h15);
    endtask

    task automatic t_neg_offset;
        lat = 0;
        mem[11] = 64'h0000_0003_0000_0000;
        run_op("R1", 32'h01, 2'b10, 64'h64, 16'hFFF8, 64'h4, 0, 0); // 0x64-8 = 0x5C, high lane
        chk(mem[11] == 64'h0000_0007_0000_0000, "R1", "negative offset lane", mem[11],
            64'h0000_0007_0000_0000);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_simple_ops();
        t_word_wrap();
        t_fetch();
        t_xchg();
        t_cmpx();
        t_illegal();
        t_busy_ignore();
        t_neg_offset();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule